// File: doc/BRIEF.md
# Compact ALU with Flags and Cycle Sequencing

This block is the arithmetic and logic unit for a processor whose instructions are 16 bits wide and whose datapath is 32 bits wide. Each operation takes a 4-bit operation code, two register operands (`op_a_i` is the destination/first operand and `op_b_i` is the second operand) and the incoming carry and overflow flags. It returns a result, the four condition flags N, Z, C and V, and a write-back strobe.

Most operations finish in the cycle they are issued. Register-amount shifts take one extra internal cycle. Multiplication takes one to four extra internal cycles, and the count depends on how far the multiplier operand is sign-extended. During these extra cycles `busy_o` is high. One cycle after the last extra cycle, `done_o` pulses and the stored outputs are presented.

The controlling pipeline drives `issue_i` for one cycle when the block is idle. It reads the outputs in the cycle that `done_o` is high.

Top module: `cisa_alu`

## Requirements
- R1: Operation codes are: 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. The logical results are a&b (AND, TST), a^b, a|b, a&~b (BIC) and ~b (MVN).
- R2: For every operation, N equals bit 31 of the result, and Z is 1 exactly when all 32 result bits are zero.
- R3: `wb_en_o` is high in the done cycle of every operation except TST, CMP and CMN, which update the flags only. It is never high outside a done cycle.
- R4: ADC gives a+b+C. SBC gives a-b-(1-C). CMP gives a-b. CMN gives a+b. NEG gives 0-b. For all five, C is the adder carry-out (for subtraction, 1 means no borrow) and V is signed overflow.
- R5: AND, EOR, ORR, BIC, MVN, TST and MUL return C and V unchanged from `c_i` and `v_i`.
- R6: LSL shifts by `op_b_i[7:0]`:
  - an amount of 0 returns a with C unchanged;
  - an amount of 1..31 sets C to the last bit shifted out;
  - an amount of 32 gives 0 with C=a[0];
  - an amount above 32 gives 0 with C=0.
- R7: LSR and ASR shift by `op_b_i[7:0]`:
  - an amount of 0 returns a with C unchanged;
  - an amount of 1..31 sets C to the last bit shifted out;
  - LSR by 32 gives 0 with C=a[31], and LSR above 32 gives 0 with C=0;
  - ASR by 32 or more fills every bit with a[31] and sets C=a[31].
- R8: ROR rotates right by `op_b_i[4:0]`:
  - an amount byte of 0 returns a with C unchanged;
  - a nonzero amount byte whose low five bits are 0 returns a with C=a[31];
  - any other amount sets C to result bit 31.
- R9: Operations other than shifts and MUL assert `done_o` in the issue cycle with valid outputs. LSL, LSR, ASR and ROR always take exactly one extra cycle.
- R10: MUL takes m extra cycles, chosen from `op_b_i` using the first rule that holds:
  - m=1 when bits 31:8 are all equal;
  - m=2 when bits 31:16 are all equal;
  - m=3 when bits 31:24 are all equal;
  - m=4 otherwise.
- R11: For an operation with m extra cycles:
  - `busy_o` is high for exactly m cycles, starting in the cycle after issue;
  - `done_o` pulses for one cycle immediately after them;
  - `issue_i` is ignored while `busy_o` is high and during that done cycle.
- R12: MUL returns the low 32 bits of a*b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Start an operation (accepted when idle) |
| opcode_i | input | 4 | Operation code (see R1) |
| op_a_i | input | 32 | First operand (destination register value) |
| op_b_i | input | 32 | Second operand (source register, shift amount, multiplier) |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| busy_o | output | 1 | Extra internal cycle in progress |
| done_o | output | 1 | Outputs valid this cycle |
| result_o | output | 32 | Result value |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| wb_en_o | output | 1 | Write the result back to the register file |

## Verification
A zero-latency operation is due in its own issue cycle. The bench checks it a short delay after driving the inputs, before the capturing edge.

An operation with m extra cycles is checked differently. In each of the following m cycles the bench checks that `busy_o` is high and `done_o` is low. In cycle m+1 it checks the full set of outputs against a behavioural model. In the cycle after that it checks that `done_o` has dropped.

During the busy cycles the bench drives a conflicting issue. The outputs it later compares show that this issue was ignored.

// File: rtl/cisa_alu_pkg.sv
package cisa_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
    OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
    OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/cisa_alu_shifter.sv
module cisa_alu_shifter import cisa_alu_pkg::*; #(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  shift_kind_e     kind_i,
  input  logic [DW-1:0]   val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic            c_i,
  output logic [DW-1:0]   res_o,
  output logic            c_o
);
  localparam int SHW = $clog2(DW);

  logic [SHW-1:0] amt_lo;
  logic           amt_zero, amt_lt, amt_eq;
  logic [DW:0]    lsl_t, lsr_t;
  logic signed [DW:0] asr_t;
  logic [2*DW-1:0] rot_t;

  assign amt_lo   = amt_i[SHW-1:0];
  assign amt_zero = (amt_i == '0);
  assign amt_lt   = (32'(amt_i) < 32'(DW));
  assign amt_eq   = (32'(amt_i) == 32'(DW));

  always_comb begin
    lsl_t = {1'b0, val_i} << amt_lo;
    lsr_t = {val_i, 1'b0} >> amt_lo;
    asr_t = $signed({val_i, 1'b0}) >>> amt_lo;
    rot_t = {val_i, val_i} >> amt_lo;
    res_o = val_i;
    c_o   = c_i;
    if (!amt_zero) begin
      unique case (kind_i)
        SH_LSL: begin
          if (amt_lt)      begin res_o = lsl_t[DW-1:0]; c_o = lsl_t[DW]; end
          else if (amt_eq) begin res_o = '0; c_o = val_i[0]; end
          else             begin res_o = '0; c_o = 1'b0; end
        end
        SH_LSR: begin
          if (amt_lt)      begin res_o = lsr_t[DW:1]; c_o = lsr_t[0]; end
          else if (amt_eq) begin res_o = '0; c_o = val_i[DW-1]; end
          else             begin res_o = '0; c_o = 1'b0; end
        end
        SH_ASR: begin
          if (amt_lt) begin res_o = asr_t[DW:1]; c_o = asr_t[0]; end
          else        begin res_o = {DW{val_i[DW-1]}}; c_o = val_i[DW-1]; end
        end
        default: begin
          res_o = rot_t[DW-1:0];
          c_o   = rot_t[DW-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/cisa_alu_addsub.sv
module cisa_alu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  logic [DW-1:0] y_eff;

  assign y_eff = sub_i ? ~y_i : y_i;
  assign {cout_o, sum_o} = {1'b0, x_i} + {1'b0, y_eff} + {{DW{1'b0}}, cin_i};
  assign ovf_o = (x_i[DW-1] == y_eff[DW-1]) && (sum_o[DW-1] != x_i[DW-1]);
endmodule

// File: rtl/cisa_alu_lat.sv
module cisa_alu_lat import cisa_alu_pkg::*; #(
  parameter int DW = 32,
  parameter int LW = 3
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] mplr_i,
  output logic [LW-1:0] lat_o
);
  localparam int NB = DW / 8;

  logic [LW-1:0] mul_m;
  logic [DW-1:0] msk, hi;

  // smallest byte boundary above which the multiplier is pure sign extension
  always_comb begin
    mul_m = LW'(NB);
    msk   = '0;
    hi    = '0;
    for (int k = NB - 1; k >= 1; k--) begin
      msk = {DW{1'b1}} << (8 * k);
      hi  = mplr_i & msk;
      if (hi == '0 || hi == msk) mul_m = LW'(k);
    end
  end

  always_comb begin
    unique case (op_i)
      OP_LSL, OP_LSR, OP_ASR, OP_ROR: lat_o = LW'(1);
      OP_MUL:                         lat_o = mul_m;
      default:                        lat_o = '0;
    endcase
  end
endmodule

// File: rtl/cisa_alu_seq.sv
module cisa_alu_seq import cisa_alu_pkg::*; #(
  parameter int DW = 32,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [LW-1:0] lat_i,
  input  logic [DW-1:0] res_i,
  input  alu_flags_t    flags_i,
  input  logic          wb_i,
  output logic          idle_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] res_o,
  output alu_flags_t    flags_o,
  output logic          wb_o
);
  logic [LW-1:0] cnt_q;
  logic          pend_q;
  logic          load;

  assign busy_o = (cnt_q != '0);
  assign done_o = pend_q;
  assign idle_o = !busy_o && !pend_q;
  assign load   = issue_i && idle_o && (lat_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
      wb_o    <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      if (load) begin
        cnt_q   <= lat_i;
        res_o   <= res_i;
        flags_o <= flags_i;
        wb_o    <= wb_i;
      end else if (busy_o) begin
        cnt_q <= cnt_q - LW'(1);
        if (cnt_q == LW'(1)) pend_q <= 1'b1;
      end
    end
  end

  p_busy_not_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LW'(1)) |=> busy_o);
  p_last_then_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == LW'(1)) |=> (done_o && !busy_o));
  p_hold_while_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$rose(busy_o)) |-> $stable(res_o));
endmodule

// File: rtl/cisa_alu.sv
module cisa_alu import cisa_alu_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [3:0]    opcode_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic          c_i,
  input  logic          v_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o,
  output logic          v_o,
  output logic          wb_en_o
);
  localparam int NB    = DW / 8;
  localparam int LW    = $clog2(NB + 1);
  localparam int AMT_W = 8;

  alu_op_e       op;
  shift_kind_e   sh_kind;
  logic [DW-1:0] sh_res, as_x, as_y, as_sum, mul_res;
  logic          sh_c, as_sub, as_cin, as_cout, as_ovf;
  logic [DW-1:0] comb_res;
  logic          comb_c, comb_v, comb_wb;
  alu_flags_t    comb_flags, seq_flags;
  logic [LW-1:0] lat;
  logic          seq_idle, seq_done, seq_wb;
  logic [DW-1:0] seq_res;
  logic          now_done;

  assign op = alu_op_e'(opcode_i);

  always_comb begin
    unique case (op)
      OP_LSL:  sh_kind = SH_LSL;
      OP_LSR:  sh_kind = SH_LSR;
      OP_ASR:  sh_kind = SH_ASR;
      default: sh_kind = SH_ROR;
    endcase
  end

  cisa_alu_shifter #(.DW(DW), .AMT_W(AMT_W)) u_shifter (
    .kind_i (sh_kind),
    .val_i  (op_a_i),
    .amt_i  (op_b_i[AMT_W-1:0]),
    .c_i    (c_i),
    .res_o  (sh_res),
    .c_o    (sh_c)
  );

  always_comb begin
    as_x   = op_a_i;
    as_y   = op_b_i;
    as_sub = 1'b0;
    as_cin = 1'b0;
    unique case (op)
      OP_ADC: as_cin = c_i;
      OP_SBC: begin as_sub = 1'b1; as_cin = c_i; end
      OP_CMP: begin as_sub = 1'b1; as_cin = 1'b1; end
      OP_NEG: begin as_x = '0; as_sub = 1'b1; as_cin = 1'b1; end
      default: ;
    endcase
  end

  cisa_alu_addsub #(.DW(DW)) u_addsub (
    .x_i    (as_x),
    .y_i    (as_y),
    .sub_i  (as_sub),
    .cin_i  (as_cin),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf)
  );

  assign mul_res = op_a_i * op_b_i;

  always_comb begin
    comb_res = '0;
    comb_c   = c_i;
    comb_v   = v_i;
    comb_wb  = 1'b1;
    unique case (op)
      OP_AND, OP_TST: comb_res = op_a_i & op_b_i;
      OP_EOR:         comb_res = op_a_i ^ op_b_i;
      OP_ORR:         comb_res = op_a_i | op_b_i;
      OP_BIC:         comb_res = op_a_i & ~op_b_i;
      OP_MVN:         comb_res = ~op_b_i;
      OP_MUL:         comb_res = mul_res;
      OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
        comb_res = sh_res;
        comb_c   = sh_c;
      end
      default: begin
        comb_res = as_sum;
        comb_c   = as_cout;
        comb_v   = as_ovf;
      end
    endcase
    if (op == OP_TST || op == OP_CMP || op == OP_CMN) comb_wb = 1'b0;
  end

  assign comb_flags = '{n: comb_res[DW-1], z: (comb_res == '0), c: comb_c, v: comb_v};

  cisa_alu_lat #(.DW(DW), .LW(LW)) u_lat (
    .op_i   (op),
    .mplr_i (op_b_i),
    .lat_o  (lat)
  );

  cisa_alu_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue_i),
    .lat_i   (lat),
    .res_i   (comb_res),
    .flags_i (comb_flags),
    .wb_i    (comb_wb),
    .idle_o  (seq_idle),
    .busy_o  (busy_o),
    .done_o  (seq_done),
    .res_o   (seq_res),
    .flags_o (seq_flags),
    .wb_o    (seq_wb)
  );

  assign now_done = issue_i && seq_idle && (lat == '0);
  assign done_o   = seq_done || now_done;

  always_comb begin
    if (seq_done) begin
      result_o = seq_res;
      {n_o, z_o, c_o, v_o} = seq_flags;
      wb_en_o  = seq_wb;
    end else begin
      result_o = comb_res;
      {n_o, z_o, c_o, v_o} = comb_flags;
      wb_en_o  = now_done && comb_wb;
    end
  end

  p_wb_in_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);
  p_z_matches_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (z_o == (result_o == '0)));
  p_shift_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && seq_idle && (op == OP_LSL || op == OP_LSR || op == OP_ASR || op == OP_ROR))
    |=> busy_o ##1 (done_o && !busy_o));
  p_mul_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && seq_idle && op == OP_MUL) |=> busy_o);
  p_zero_lat_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !busy_o && !seq_done && lat == '0) |-> done_o);
endmodule

// File: tb/cisa_alu_bench.sv
module cisa_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        cin = 1'b0, vin = 1'b0;
  logic        busy, done, n, z, c, v, wb;
  logic [31:0] res;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  cisa_alu u_cisa_alu (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .opcode_i(opcode),
    .op_a_i(op_a), .op_b_i(op_b), .c_i(cin), .v_i(vin),
    .busy_o(busy), .done_o(done), .result_o(res),
    .n_o(n), .z_o(z), .c_o(c), .v_o(v), .wb_en_o(wb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  task automatic model(input int op, input logic [31:0] a, b, input logic ci, vi,
                       output logic [31:0] r, output logic co, vo, wbo, output int lat);
    longint unsigned s;
    int amt;
    int rr;
    amt = int'(b[7:0]);
    r = 0; co = ci; vo = vi; wbo = 1; lat = 0;
    case (op)
      0, 8: r = a & b;
      1:    r = a ^ b;
      12:   r = a | b;
      14:   r = a & ~b;
      15:   r = ~b;
      13: begin
        r = a * b;
        if (b[31:8] == 24'h0 || b[31:8] == 24'hFFFFFF) lat = 1;
        else if (b[31:16] == 16'h0 || b[31:16] == 16'hFFFF) lat = 2;
        else if (b[31:24] == 8'h0 || b[31:24] == 8'hFF) lat = 3;
        else lat = 4;
      end
      5, 11: begin
        s = longint'(a) + longint'(b) + ((op == 5) ? longint'(ci) : 0);
        r = s[31:0]; co = s[32];
        vo = (a[31] == b[31]) && (r[31] != a[31]);
      end
      6, 10, 9: begin
        logic [31:0] x;
        logic bor;
        x = (op == 9) ? 32'h0 : a;
        bor = (op == 6) ? !ci : 1'b0;
        r = x - b - 32'(bor);
        co = (longint'(x) >= longint'(b) + longint'(bor));
        vo = (x[31] != b[31]) && (r[31] != x[31]);
      end
      2: begin
        lat = 1;
        if (amt == 0) r = a;
        else if (amt < 32) begin r = a << amt; co = a[32 - amt]; end
        else if (amt == 32) begin r = 0; co = a[0]; end
        else begin r = 0; co = 0; end
      end
      3: begin
        lat = 1;
        if (amt == 0) r = a;
        else if (amt < 32) begin r = a >> amt; co = a[amt - 1]; end
        else if (amt == 32) begin r = 0; co = a[31]; end
        else begin r = 0; co = 0; end
      end
      4: begin
        lat = 1;
        if (amt == 0) r = a;
        else if (amt < 32) begin r = 32'($signed(a) >>> amt); co = a[amt - 1]; end
        else begin r = {32{a[31]}}; co = a[31]; end
      end
      default: begin
        lat = 1;
        rr = amt % 32;
        if (amt == 0) r = a;
        else if (rr == 0) begin r = a; co = a[31]; end
        else begin r = (a >> rr) | (a << (32 - rr)); co = r[31]; end
      end
    endcase
    if (op == 8 || op == 10 || op == 11) wbo = 0;
  endtask

  task automatic cmp_all(input string tag, input logic [31:0] er, input logic ec, ev, ew);
    chk({tag, " R1/R4/R6/R7/R8/R12 result"}, res, er);
    chk({tag, " R2 N"}, 32'(n), 32'(er[31]));
    chk({tag, " R2 Z"}, 32'(z), 32'(er == 0));
    chk({tag, " R4/R5 C"}, 32'(c), 32'(ec));
    chk({tag, " R4/R5 V"}, 32'(v), 32'(ev));
    chk({tag, " R3 wb"}, 32'(wb), 32'(ew));
  endtask

  task automatic run(input int op, input logic [31:0] a, b, input logic ci, vi, input string tag);
    logic [31:0] er;
    logic ec, ev, ew;
    int lat;
    model(op, a, b, ci, vi, er, ec, ev, ew, lat);
    @(negedge clk);
    chk({tag, " R11 idle busy"}, 32'(busy), 0);
    chk({tag, " R11 idle done"}, 32'(done), 0);
    opcode = 4'(op); op_a = a; op_b = b; cin = ci; vin = vi; issue = 1'b1;
    #2;
    if (lat == 0) begin
      chk({tag, " R9 same-cycle done"}, 32'(done), 1);
      cmp_all(tag, er, ec, ev, ew);
      issue = 1'b0;
    end else begin
      chk({tag, " R9/R10 not done at issue"}, 32'(done), 0);
      chk({tag, " R3 no wb at issue"}, 32'(wb), 0);
      @(negedge clk);
      // conflicting issue while busy must be ignored (R11)
      opcode = 4'd15; op_a = 32'h0; op_b = 32'h0; cin = ~ci; vin = ~vi; issue = 1'b1;
      for (int k = 1; k <= lat; k++) begin
        #2;
        chk({tag, " R10/R11 busy"}, 32'(busy), 1);
        chk({tag, " R11 no done while busy"}, 32'(done), 0);
        chk({tag, " R3 no wb while busy"}, 32'(wb), 0);
        @(negedge clk);
      end
      issue = 1'b0;
      #2;
      chk({tag, " R11 done after extra cycles"}, 32'(done), 1);
      chk({tag, " R11 busy low at done"}, 32'(busy), 0);
      cmp_all(tag, er, ec, ev, ew);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #35;
    chk("R11 reset busy", 32'(busy), 0);
    chk("R11 reset done", 32'(done), 0);
    chk("R3 reset wb", 32'(wb), 0);
    rst_n = 1'b1;
    // R1 / R5 logical, flags passthrough
    run(0,  32'hF0F0_1234, 32'h0FF0_FF00, 1, 1, "AND");
    run(1,  32'hAAAA_5555, 32'hFFFF_0000, 0, 1, "EOR");
    run(12, 32'h0000_0000, 32'h0000_0000, 1, 0, "ORR zero");
    run(14, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, "BIC");
    run(15, 32'h1234_5678, 32'h0000_0000, 1, 1, "MVN");
    run(8,  32'h8000_0000, 32'h8000_0001, 0, 1, "TST R3");
    // R4 arithmetic
    run(5,  32'hFFFF_FFFF, 32'h0000_0000, 1, 0, "ADC carry-in");
    run(5,  32'h7FFF_FFFF, 32'h0000_0001, 0, 0, "ADC ovf");
    run(6,  32'h0000_0005, 32'h0000_0005, 0, 0, "SBC borrow");
    run(6,  32'h8000_0000, 32'h0000_0001, 1, 0, "SBC ovf");
    run(10, 32'h0000_0003, 32'h0000_0003, 0, 1, "CMP equal R3");
    run(10, 32'h0000_0001, 32'h0000_0002, 1, 0, "CMP less R3");
    run(11, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "CMN R3");
    run(9,  32'hDEAD_BEEF, 32'h0000_0000, 0, 1, "NEG zero");
    run(9,  32'h0,         32'h8000_0000, 0, 0, "NEG min");
    run(9,  32'h0,         32'h0000_0007, 1, 1, "NEG");
    // R6 LSL
    run(2, 32'h8000_0001, 32'h0000_0000, 1, 0, "LSL 0");
    run(2, 32'h8000_0001, 32'h0000_0001, 0, 0, "LSL 1");
    run(2, 32'h0000_0003, 32'h0000_001F, 0, 1, "LSL 31");
    run(2, 32'h0000_0001, 32'h0000_0020, 0, 0, "LSL 32");
    run(2, 32'hFFFF_FFFF, 32'h0000_0021, 1, 0, "LSL 33");
    run(2, 32'hFFFF_FFFF, 32'hFFFF_FF00, 1, 0, "LSL byte only");
    // R7 LSR / ASR
    run(3, 32'h8000_0001, 32'h0000_0000, 0, 0, "LSR 0");
    run(3, 32'h8000_0001, 32'h0000_0001, 0, 0, "LSR 1");
    run(3, 32'h8000_0000, 32'h0000_0020, 0, 0, "LSR 32");
    run(3, 32'hFFFF_FFFF, 32'h0000_00FF, 1, 0, "LSR 255");
    run(4, 32'h8000_00F0, 32'h0000_0004, 0, 1, "ASR 4");
    run(4, 32'h8000_0000, 32'h0000_0028, 0, 0, "ASR 40 neg");
    run(4, 32'h7FFF_FFFF, 32'h0000_0020, 1, 0, "ASR 32 pos");
    // R8 ROR
    run(7, 32'h0000_0001, 32'h0000_0000, 1, 0, "ROR 0");
    run(7, 32'h0000_0001, 32'h0000_0001, 0, 0, "ROR 1");
    run(7, 32'h8000_0000, 32'h0000_0020, 0, 0, "ROR 32");
    run(7, 32'h1234_5678, 32'h0000_0044, 0, 0, "ROR 68");
    // R10 / R12 MUL latency classes
    run(13, 32'h0000_0003, 32'h0000_007F, 1, 1, "MUL m1 pos");
    run(13, 32'h0000_0005, 32'hFFFF_FF80, 0, 1, "MUL m1 neg");
    run(13, 32'h0001_0001, 32'h0000_1234, 1, 0, "MUL m2 pos");
    run(13, 32'hFFFF_FFFF, 32'hFFFF_8000, 0, 0, "MUL m2 neg");
    run(13, 32'h0000_0010, 32'h0012_3456, 0, 1, "MUL m3");
    run(13, 32'h0000_0002, 32'hFF80_0000, 1, 1, "MUL m3 neg");
    run(13, 32'h9ABC_DEF0, 32'h1234_5678, 0, 0, "MUL m4");
    run(13, 32'h0000_0000, 32'h8000_0000, 1, 0, "MUL m4 zero");
    @(negedge clk);
    chk("R11 final done low", 32'(done), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule